// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Engine

This block moves data between a disk drive's 16-bit word stream and system memory. Software places a table of 8-byte descriptors in memory and loads the table's address into a pointer register. It then sets the start bit in the command register, which also selects the direction. Each descriptor names a buffer and a byte count. The engine fetches the descriptors one after another and streams words into or out of each buffer. It stops after the descriptor that carries the end flag.

When the table is finished the engine raises an interrupt flag in its status register and goes inactive. It raises an error flag in two cases. The first is a drive that keeps delivering data after the table is used up. The second is a table that runs past the maximum entry count without an end flag. Software clears the start bit once it has seen the result, clears the flags by writing ones to them, and then programs the next transfer.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the command, status and pointer registers all read 0, and no memory strobe, drive-side ready or drive-side valid is asserted.
- R2: Register offset 0 is the command register: bit 0 is start and bit 3 is direction (1 moves drive to memory, 0 moves memory to drive). Offset 1 is status and offset 2 is the 32-bit table pointer. The pointer reads back with bits [1:0] as zero.
- R3: A write that changes start from 0 to 1 makes the engine read each descriptor from the table pointer in 8-byte steps. The 32-bit word at the descriptor's offset 0 is the buffer address, with bit 0 ignored. In the word at offset 4, bits [15:0] are the byte count with bit 0 ignored, and bit 31 is the end flag.
- R4: In the drive-to-memory direction, each accepted drive word (valid and ready high at a clock edge) is written to the next halfword of the buffer. The low byte goes to the even address.
- R5: In the memory-to-drive direction, the halfwords of each buffer are offered on the drive output in address order, and one is consumed per edge with valid and ready high.
- R6: A byte count whose bits [15:1] are all zero moves 65536 bytes (32768 words).
- R7: Within one descriptor, the buffer address wraps inside its 64 KiB region: bits [31:16] never change while its words move.
- R8: After the last word of the descriptor with the end flag, status bit 2 (interrupt) reads 1 and status bit 0 (active) reads 0.
- R9: In the drive-to-memory direction, a drive word offered after the table is done, while start is still set, is consumed without a memory write and sets status bit 1 (error).
- R10: If MAX_DESC descriptors complete and none has the end flag, the engine sets the error bit, leaves the interrupt bit clear and goes inactive.
- R11: Status bit 0 reads 1 from the cycle after the starting write until the transfer ends.
- R12: From the cycle after a write that clears start, the engine is inactive. It accepts and offers no drive words and makes no memory access.
- R13: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 to either bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 command, 1 status, 2 pointer) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| memRd | output | 1 | Memory read strobe (data returned in the same cycle) |
| memWr | output | 1 | Memory halfword write strobe |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 16 | Memory write halfword |
| memRData | input | 32 | Memory read data, little-endian from memAddr |
| drvInValid | input | 1 | Drive word available (drive to memory) |
| drvInReady | output | 1 | Engine accepts a drive word |
| drvInData | input | 16 | Drive word in |
| drvOutValid | output | 1 | Engine offers a word to the drive |
| drvOutReady | input | 1 | Drive takes the offered word |
| drvOutData | output | 16 | Word to the drive |

## Verification
The hardest cases to reach from the ports are the zero byte count and the address wrap. A zero count must move 32768 words and then stop on exactly the last one. A wrapped address must fold back to the start of its 64 KiB region and not step into the next one. The bench models memory by folding address bit 16 and bits [10:0] into a 4 KiB array. This lets one region hold a full 65536-byte buffer, while a write that escapes a region lands in a cell that was prefilled and then checked. The table-limit fault is reached by building the engine with a small maximum descriptor count.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_PTR  = 2'd2;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ACTIVE_BIT = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_IRQ_BIT    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_ADDR,
    ST_FETCH_CNT,
    ST_MOVE,
    ST_DONE
  } dmaState_e;

  typedef enum logic [1:0] {
    SRC_DESC_ADDR,
    SRC_DESC_CNT,
    SRC_BUF
  } memSrc_e;

  typedef struct packed {
    logic    loadPtr;
    logic    loadBuf;
    logic    loadCnt;
    logic    step;
    memSrc_e memSrc;
  } dpCtrl_t;

endpackage

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              irqSet,
  input  logic              errSet,
  input  logic              engActive,
  output logic              startBit,
  output logic              startPulse,
  output logic              launchDir,
  output logic [ADDR_W-1:0] tablePtr
);

  logic dirBit;
  logic irqFlag;
  logic errFlag;
  logic cmdWr;
  logic statWr;
  logic ptrWr;

  assign cmdWr  = regWrEn && (regAddr == REG_CMD);
  assign statWr = regWrEn && (regAddr == REG_STAT);
  assign ptrWr  = regWrEn && (regAddr == REG_PTR);

  assign startPulse = cmdWr && regWrData[CMD_START_BIT] && !startBit;
  assign launchDir  = regWrData[CMD_DIR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0;
      dirBit   <= 1'b0;
      tablePtr <= '0;
      irqFlag  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (cmdWr) begin
        startBit <= regWrData[CMD_START_BIT];
        dirBit   <= regWrData[CMD_DIR_BIT];
      end
      if (ptrWr) begin
        tablePtr <= {regWrData[ADDR_W-1:2], 2'b00};
      end
      irqFlag <= irqSet | (irqFlag & ~(statWr & regWrData[ST_IRQ_BIT]));
      errFlag <= errSet | (errFlag & ~(statWr & regWrData[ST_ERR_BIT]));
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CMD: begin
        regRdData[CMD_START_BIT] = startBit;
        regRdData[CMD_DIR_BIT]   = dirBit;
      end
      REG_STAT: begin
        regRdData[ST_ACTIVE_BIT] = engActive;
        regRdData[ST_ERR_BIT]    = errFlag;
        regRdData[ST_IRQ_BIT]    = irqFlag;
      end
      REG_PTR: regRdData = tablePtr;
      default: regRdData = '0;
    endcase
  end

  // R13: a write of one clears the interrupt flag unless a new completion arrives
  p_irq_w1c_r13: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && regWrData[ST_IRQ_BIT] && !irqSet) |=> !irqFlag);

  // R13: without a status write the interrupt flag holds
  p_irq_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !statWr) |=> irqFlag);

  // R8: completion is reported only once the engine has gone inactive
  p_irq_inactive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !engActive);

endmodule

// File: rtl/sg_dma_ctrl.sv
module sg_dma_ctrl
  import sg_dma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startBit,
  input  logic    startPulse,
  input  logic    launchDir,
  input  logic    drvInValid,
  input  logic    drvOutReady,
  input  logic    lastWord,
  input  logic    endFlag,
  input  logic    tableFull,
  output dpCtrl_t dp,
  output logic    memRd,
  output logic    memWr,
  output logic    drvInReady,
  output logic    drvOutValid,
  output logic    engActive,
  output logic    irqSet,
  output logic    errSet
);

  dmaState_e state;
  dmaState_e nextState;
  logic      dirRead;
  logic      handshake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dirRead <= 1'b0;
    end else begin
      state <= nextState;
      if (startPulse) begin
        dirRead <= launchDir;
      end
    end
  end

  always_comb begin
    nextState   = state;
    dp          = '0;
    dp.memSrc   = SRC_BUF;
    memRd       = 1'b0;
    memWr       = 1'b0;
    drvInReady  = 1'b0;
    drvOutValid = 1'b0;
    irqSet      = 1'b0;
    errSet      = 1'b0;
    handshake   = 1'b0;
    case (state)
      ST_IDLE: nextState = ST_IDLE;
      ST_FETCH_ADDR: begin
        memRd      = 1'b1;
        dp.memSrc  = SRC_DESC_ADDR;
        dp.loadBuf = 1'b1;
        nextState  = ST_FETCH_CNT;
      end
      ST_FETCH_CNT: begin
        memRd      = 1'b1;
        dp.memSrc  = SRC_DESC_CNT;
        dp.loadCnt = 1'b1;
        nextState  = ST_MOVE;
      end
      ST_MOVE: begin
        if (dirRead) begin
          drvInReady = 1'b1;
          handshake  = drvInValid;
          memWr      = drvInValid;
        end else begin
          drvOutValid = 1'b1;
          memRd       = 1'b1;
          handshake   = drvOutReady;
        end
        if (handshake) begin
          dp.step = 1'b1;
          if (lastWord) begin
            if (endFlag) begin
              irqSet    = 1'b1;
              nextState = ST_DONE;
            end else if (tableFull) begin
              errSet    = 1'b1;
              nextState = ST_DONE;
            end else begin
              nextState = ST_FETCH_ADDR;
            end
          end
        end
      end
      ST_DONE: begin
        if (dirRead) begin
          drvInReady = 1'b1;
          errSet     = drvInValid;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (!startBit) begin
      memRd       = 1'b0;
      memWr       = 1'b0;
      drvInReady  = 1'b0;
      drvOutValid = 1'b0;
      irqSet      = 1'b0;
      errSet      = 1'b0;
      dp.step     = 1'b0;
      dp.loadBuf  = 1'b0;
      dp.loadCnt  = 1'b0;
      dp.loadPtr  = startPulse;
      nextState   = startPulse ? ST_FETCH_ADDR : ST_IDLE;
    end
  end

  assign engActive = startBit &&
                     ((state == ST_FETCH_ADDR) || (state == ST_FETCH_CNT) || (state == ST_MOVE));

  // R3: the address word of a descriptor is followed by its count word
  p_fetch_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH_ADDR && startBit) |=> (state == ST_FETCH_CNT));

  // R12: once start drops the engine is silent on every port
  p_stop_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> (!memWr && !memRd && !drvInReady && !drvOutValid && !engActive));

  // R4: one memory access per cycle
  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memWr && memRd));

  // R9: an excess drive word never reaches memory
  p_overrun_nowrite_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && drvInValid) |-> !memWr);

endmodule

// File: rtl/sg_dma_datapath.sv
module sg_dma_datapath
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int MAX_DESC = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic [ADDR_W-1:0] tablePtr,
  input  logic [ADDR_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastWord,
  output logic              endFlag,
  output logic              tableFull
);

  localparam int WORDS_W  = CNT_W - 1;
  localparam int REGION_W = CNT_W;
  localparam int IDX_W    = $clog2(MAX_DESC + 1);
  localparam int DESC_B   = 8;
  localparam int CNT_OFS  = 4;

  logic [ADDR_W-1:0]  descPtr;
  logic [ADDR_W-1:0]  bufAddr;
  logic [WORDS_W-1:0] wordsLeft;
  logic [IDX_W-1:0]   descIdx;
  logic               unusedBits;

  assign unusedBits = ^{memRData[0], tablePtr[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr   <= '0;
      bufAddr   <= '0;
      wordsLeft <= '0;
      endFlag   <= 1'b0;
      descIdx   <= '0;
    end else begin
      if (dp.loadPtr) begin
        descPtr <= {tablePtr[ADDR_W-1:2], 2'b00};
        descIdx <= '0;
      end
      if (dp.loadBuf) begin
        bufAddr <= {memRData[ADDR_W-1:1], 1'b0};
      end
      if (dp.loadCnt) begin
        wordsLeft <= memRData[CNT_W-1:1] - WORDS_W'(1);
        endFlag   <= memRData[ADDR_W-1];
        descPtr   <= descPtr + ADDR_W'(DESC_B);
        descIdx   <= descIdx + IDX_W'(1);
      end
      if (dp.step) begin
        bufAddr[REGION_W-1:0] <= bufAddr[REGION_W-1:0] + REGION_W'(2);
        wordsLeft             <= wordsLeft - WORDS_W'(1);
      end
    end
  end

  always_comb begin
    case (dp.memSrc)
      SRC_DESC_ADDR: memAddr = descPtr;
      SRC_DESC_CNT:  memAddr = descPtr + ADDR_W'(CNT_OFS);
      default:       memAddr = bufAddr;
    endcase
  end

  assign lastWord  = (wordsLeft == '0);
  assign tableFull = (descIdx == IDX_W'(MAX_DESC));

  // R7: stepping through a buffer never changes its 64 KiB region
  p_region_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dp.step && !dp.loadBuf) |=> (bufAddr[ADDR_W-1:REGION_W] == $past(bufAddr[ADDR_W-1:REGION_W])));

  // R10: the descriptor index never runs past the table limit
  p_idx_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    descIdx <= IDX_W'(MAX_DESC));

endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int MAX_DESC = 8192,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memRd,
  output logic        memWr,
  output logic [31:0] memAddr,
  output logic [15:0] memWData,
  input  logic [31:0] memRData,
  input  logic        drvInValid,
  output logic        drvInReady,
  input  logic [15:0] drvInData,
  output logic        drvOutValid,
  input  logic        drvOutReady,
  output logic [15:0] drvOutData
);

  localparam int ADDR_W = 32;

  dpCtrl_t           dp;
  logic              startBit;
  logic              startPulse;
  logic              launchDir;
  logic [ADDR_W-1:0] tablePtr;
  logic              irqSet;
  logic              errSet;
  logic              engActive;
  logic              lastWord;
  logic              endFlag;
  logic              tableFull;

  sg_dma_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .irqSet     (irqSet),
    .errSet     (errSet),
    .engActive  (engActive),
    .startBit   (startBit),
    .startPulse (startPulse),
    .launchDir  (launchDir),
    .tablePtr   (tablePtr)
  );

  sg_dma_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startBit    (startBit),
    .startPulse  (startPulse),
    .launchDir   (launchDir),
    .drvInValid  (drvInValid),
    .drvOutReady (drvOutReady),
    .lastWord    (lastWord),
    .endFlag     (endFlag),
    .tableFull   (tableFull),
    .dp          (dp),
    .memRd       (memRd),
    .memWr       (memWr),
    .drvInReady  (drvInReady),
    .drvOutValid (drvOutValid),
    .engActive   (engActive),
    .irqSet      (irqSet),
    .errSet      (errSet)
  );

  sg_dma_datapath #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MAX_DESC (MAX_DESC)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .dp        (dp),
    .tablePtr  (tablePtr),
    .memRData  (memRData),
    .memAddr   (memAddr),
    .lastWord  (lastWord),
    .endFlag   (endFlag),
    .tableFull (tableFull)
  );

  assign memWData   = drvInData;
  assign drvOutData = memRData[15:0];

endmodule

// File: tb/sg_dma_engine_tb_top.sv
module sg_dma_engine_tb_top;

  localparam int MAXD = 4;
  localparam logic [31:0] TBL = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memRd, memWr;
  logic [31:0] memAddr;
  logic [15:0] memWData;
  logic [31:0] memRData;
  logic        drvInValid = 1'b0;
  logic        drvInReady;
  logic [15:0] drvInData = '0;
  logic        drvOutValid;
  logic        drvOutReady = 1'b0;
  logic [15:0] drvOutData;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [4096];

  always #5 clk = ~clk;

  sg_dma_engine #(.MAX_DESC(MAXD)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .drvInValid(drvInValid), .drvInReady(drvInReady), .drvInData(drvInData),
    .drvOutValid(drvOutValid), .drvOutReady(drvOutReady), .drvOutData(drvOutData)
  );

  function automatic logic [11:0] mIdx(logic [31:0] a);
    return {a[16], a[10:0]};
  endfunction

  always_comb begin
    memRData = {mem[mIdx(memAddr + 32'd3)], mem[mIdx(memAddr + 32'd2)],
                mem[mIdx(memAddr + 32'd1)], mem[mIdx(memAddr)]};
  end

  always @(posedge clk) begin
    if (memWr) begin
      mem[mIdx(memAddr)]         = memWData[7:0];
      mem[mIdx(memAddr + 32'd1)] = memWData[15:8];
    end
  end

  function automatic logic [15:0] wordVal(int t, int i);
    return 16'(t * 4369 + i * 515 + 257);
  endfunction

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic fill(logic [31:0] base, int n);
    for (int i = 0; i < n; i++) mem[mIdx(base + 32'(i))] = 8'hEE;
  endtask

  task automatic setMem16(logic [31:0] a, logic [15:0] v);
    mem[mIdx(a)] = v[7:0];
    mem[mIdx(a + 32'd1)] = v[15:8];
  endtask

  function automatic logic [15:0] getMem16(logic [31:0] a);
    return {mem[mIdx(a + 32'd1)], mem[mIdx(a)]};
  endfunction

  task automatic putDesc(int slot, logic [31:0] addr, logic [15:0] cnt, logic endf);
    logic [31:0] base;
    base = TBL + 32'(slot * 8);
    setMem16(base, addr[15:0]);
    setMem16(base + 32'd2, addr[31:16]);
    setMem16(base + 32'd4, cnt);
    setMem16(base + 32'd6, {endf, 15'd0});
  endtask

  task automatic startRun(logic dir);
    regWrite(2'd0, 32'd0);
    regWrite(2'd1, 32'd6);
    regWrite(2'd2, TBL);
    regWrite(2'd0, {28'd0, dir, 3'b001});
  endtask

  task automatic pushWords(int n, int t, int first);
    for (int i = 0; i < n; i++) begin
      drvInData = wordVal(t, first + i);
      drvInValid = 1'b1;
      #1;
      while (!drvInReady) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    drvInValid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] dA [3];
    int dL [3];
    logic [15:0] cap [5];
    int got;
    int w;
    logic sawReady;

    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, rd); checkEq("R1 cmd", rd, 32'd0);
    regRead(2'd1, rd); checkEq("R1 status", rd, 32'd0);
    regRead(2'd2, rd); checkEq("R1 ptr", rd, 32'd0);
    checkEq("R1 strobes", {28'd0, memRd, memWr, drvInReady, drvOutValid}, 32'd0);

    // R2 pointer readback drops bits 1:0
    regWrite(2'd2, 32'h1234_5677);
    regRead(2'd2, rd); checkEq("R2 ptr", rd, 32'h1234_5674);

    // R4 R3 R8 R11 sweep over table length and buffer sizes
    for (int nd = 1; nd <= 3; nd++) begin
      fill(32'h0, 512);
      for (int k = 0; k < nd; k++) begin
        dA[k] = 32'(k * 128);
        dL[k] = 2 * (((k + nd) % 3) + 1);
        putDesc(k, dA[k], 16'(dL[k]), k == nd - 1);
      end
      w = 0;
      for (int k = 0; k < nd; k++) w += dL[k] / 2;
      startRun(1'b1);
      regRead(2'd1, rd); checkEq("R11 active after start", rd, 32'd1);
      regRead(2'd0, rd); checkEq("R2 cmd readback", rd, 32'd9);
      pushWords(w, nd, 0);
      regRead(2'd1, rd); checkEq("R8 done status", rd, 32'd4);
      w = 0;
      for (int k = 0; k < nd; k++) begin
        for (int j = 0; j < dL[k] / 2; j++) begin
          checkEq("R4 R3 buffer word", {16'd0, getMem16(dA[k] + 32'(2 * j))}, {16'd0, wordVal(nd, w)});
          w++;
        end
      end
      if (nd == 3) begin
        // R9 overrun, then R13 write-1-to-clear
        pushWords(1, 3, w);
        regRead(2'd1, rd); checkEq("R9 overrun error", rd, 32'd6);
        checkEq("R9 no write", {16'd0, getMem16(dA[2] + 32'(dL[2]))}, 32'h0000_EEEE);
        regWrite(2'd1, 32'd0);
        regRead(2'd1, rd); checkEq("R13 zero write keeps", rd, 32'd6);
        regWrite(2'd1, 32'd4);
        regRead(2'd1, rd); checkEq("R13 clear irq", rd, 32'd2);
        regWrite(2'd1, 32'd2);
        regRead(2'd1, rd); checkEq("R13 clear err", rd, 32'd0);
      end
    end

    // R5 memory to drive over two descriptors
    setMem16(32'h300, 16'h1111); setMem16(32'h302, 16'h2222);
    setMem16(32'h340, 16'h3333); setMem16(32'h342, 16'h4444); setMem16(32'h344, 16'h5555);
    putDesc(0, 32'h300, 16'd4, 1'b0);
    putDesc(1, 32'h340, 16'd6, 1'b1);
    startRun(1'b0);
    drvOutReady = 1'b1;
    got = 0;
    while (got < 5) begin
      #1;
      if (drvOutValid) begin
        cap[got] = drvOutData;
        got++;
      end
      @(negedge clk);
    end
    drvOutReady = 1'b0;
    for (int i = 0; i < 5; i++)
      checkEq("R5 drive word", {16'd0, cap[i]}, {16'd0, 16'(32'h1111 * (i + 1))});
    regRead(2'd1, rd); checkEq("R5 R8 status", rd, 32'd4);

    // R3 bit 0 of address and count ignored
    fill(32'h0, 512);
    putDesc(0, 32'h101, 16'd7, 1'b1);
    startRun(1'b1);
    pushWords(3, 6, 0);
    regRead(2'd1, rd); checkEq("R3 odd count done", rd, 32'd4);
    for (int i = 0; i < 3; i++)
      checkEq("R3 odd address", {16'd0, getMem16(32'h100 + 32'(2 * i))}, {16'd0, wordVal(6, i)});
    checkEq("R3 count bit0", {16'd0, getMem16(32'h106)}, 32'h0000_EEEE);

    // R6 zero count moves 32768 words
    putDesc(0, 32'h0001_0000, 16'd0, 1'b1);
    startRun(1'b1);
    pushWords(32767, 9, 0);
    regRead(2'd1, rd); checkEq("R6 still active", rd, 32'd1);
    pushWords(1, 9, 32767);
    regRead(2'd1, rd); checkEq("R6 done", rd, 32'd4);
    checkEq("R6 last word", {16'd0, getMem16(32'h0001_FFFE)}, {16'd0, wordVal(9, 32767)});

    // R7 wrap inside the 64 KiB region
    fill(32'h0001_0000, 2048);
    fill(32'h0, 512);
    putDesc(0, 32'h0001_FFFC, 16'd8, 1'b1);
    startRun(1'b1);
    pushWords(4, 7, 0);
    regRead(2'd1, rd); checkEq("R7 done", rd, 32'd4);
    checkEq("R7 w0", {16'd0, getMem16(32'h0001_FFFC)}, {16'd0, wordVal(7, 0)});
    checkEq("R7 w1", {16'd0, getMem16(32'h0001_FFFE)}, {16'd0, wordVal(7, 1)});
    checkEq("R7 w2 wrapped", {16'd0, getMem16(32'h0001_0000)}, {16'd0, wordVal(7, 2)});
    checkEq("R7 w3 wrapped", {16'd0, getMem16(32'h0001_0002)}, {16'd0, wordVal(7, 3)});
    checkEq("R7 next region untouched", {16'd0, getMem16(32'h0002_0000)}, 32'h0000_EEEE);

    // R10 table limit without end flag
    fill(32'h0, 512);
    for (int k = 0; k < MAXD; k++) putDesc(k, 32'(k * 64), 16'd2, 1'b0);
    startRun(1'b1);
    pushWords(MAXD, 8, 0);
    regRead(2'd1, rd); checkEq("R10 limit error", rd, 32'd2);
    for (int k = 0; k < MAXD; k++)
      checkEq("R10 words", {16'd0, getMem16(32'(k * 64))}, {16'd0, wordVal(8, k)});

    // R12 stop in the middle of a buffer
    fill(32'h0, 512);
    putDesc(0, 32'h0, 16'd16, 1'b1);
    startRun(1'b1);
    pushWords(2, 5, 0);
    regWrite(2'd0, 32'd0);
    regRead(2'd1, rd); checkEq("R12 inactive", rd, 32'd0);
    drvInValid = 1'b1;
    drvInData = 16'hBEEF;
    sawReady = 1'b0;
    repeat (3) begin
      #1;
      if (drvInReady) sawReady = 1'b1;
      @(negedge clk);
    end
    drvInValid = 1'b0;
    checkEq("R12 no ready", {31'd0, sawReady}, 32'd0);
    checkEq("R12 no write", {16'd0, getMem16(32'h4)}, 32'h0000_EEEE);
    checkEq("R12 kept words", {16'd0, getMem16(32'h2)}, {16'd0, wordVal(5, 1)});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule